// File: doc/BRIEF.md
# Interrupt Priority Selector

This block keeps one pending flag for each of seven interrupt classes and decides which class, if any, the processor should take next. A producer posts a class by pulsing a strobe with a 3-bit class code. The processor's current state comes in as plain inputs: the hypervisor-privileged flag, the global interrupt enable, the trap-level-zero enable, the current trap level, the processor interrupt level (PIL) and a 16-bit soft-interrupt register.

The choice is combinational from the pending flags and the state inputs. It is shown continuously as a cause code, with a valid flag and the soft-interrupt level being served. When the processor pulses the take strobe, the block clears the chosen class's pending flag on that clock edge and lowers a counter of untaken interrupts. Which classes compete, and in what order, depends on the privilege mode. A soft interrupt of low level gives way to a pending interrupt vector. The soft-interrupt flag stays set while other soft levels remain in the register.

Top module: `intr_arbiter`

## Requirements
- R1: After reset, every pending flag is clear, `pend_cnt` is 0, `pend_any` is low, `post_err` is low, and `take_code` is 7 (none) with `take_vld` low.
- R2: The class codes are: 0 trap-level-zero, 1 hypervisor timer match, 2 interrupt vector, 3 cpu message, 4 device message, 5 resumable error, 6 soft interrupt. A post of codes 0 to 6 sets that class's flag and raises `pend_cnt` by one. `pend_any` is high exactly when `pend_cnt` is non-zero.
- R3: A post with code 7 changes no flag and does not change the counter. It makes `post_err` high for exactly one cycle, in the cycle after the post edge.
- R4: Posting a class that is already pending leaves `pend_cnt` unchanged.
- R5: With `hpriv` high, a class is selected only when `int_en` is high. Class 1 is chosen before class 2, and every other class stays pending with `take_code` = 7.
- R6: With `hpriv` low, class 0 has top priority. It is chosen only when `tlz_en` is high and `trap_lvl` is 0. Otherwise it is skipped.
- R7: With `hpriv` low, class 1 comes after class 0 and is chosen even when `int_en` is low.
- R8: With `hpriv` low and `int_en` high, the order after class 1 is 3, then 4, then 6, then 5. With `int_en` low, none of classes 2 to 6 is chosen.
- R9: The soft level is the bit index of the highest set bit of `soft_reg`. `take_lvl` shows that level while class 6 is selected and shows 0 otherwise.
- R10: With `hpriv` low and `int_en` high, when class 6 is the candidate, its soft level is below 6 and class 2 is pending, class 2 is chosen instead.
- R11: Class 6 is chosen only when its soft level is strictly greater than `pil`. Otherwise selection falls through to class 5, or to none.
- R12: Taking class 6 clears its flag only if `soft_reg` has no set bit once the bit of the served level is masked off. Otherwise the flag and counter are unchanged.
- R13: A take with a valid selection clears that flag and lowers `pend_cnt` by one, and a take with nothing selected changes nothing. A post and a take in the same cycle update the counter by their net effect. A post of the class being taken leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld | input | 1 | Post strobe |
| post_code | input | 3 | Class code being posted |
| post_err | output | 1 | One-cycle pulse after an illegal post |
| take_req | input | 1 | Take strobe from the processor |
| hpriv | input | 1 | Hypervisor-privileged mode |
| int_en | input | 1 | Global interrupt enable |
| tlz_en | input | 1 | Trap-level-zero interrupt enable |
| trap_lvl | input | TL_W (3) | Current trap level |
| pil | input | PIL_W (4) | Processor interrupt level |
| soft_reg | input | SOFT_W (16) | Soft-interrupt register |
| take_code | output | 3 | Selected class, 7 when none |
| take_vld | output | 1 | A class is selected |
| take_lvl | output | LVL_W (4) | Soft level served, 0 if class 6 not selected |
| pend_any | output | 1 | Any interrupt pending |
| pend_cnt | output | CNT_W (3) | Number of pending classes |

## Verification
The in-RTL properties assume that `rst_n` is held low over the first edges. They also assume that the state inputs and `take_req` come from a driver that keeps them steady across a clock edge, so that the combinational selection seen at the edge is the one that gets cleared. They assume `pil` and the soft level share a width, which elaboration enforces. The bench changes every input only on the falling clock edge. It samples both the combinational selection and the registered counter half a cycle later, and it rebuilds each flag pattern from reset by posting one class per cycle, so the counter is always known.

// File: rtl/intr_pkg.sv
package intr_pkg;

   localparam int unsigned NUM_CLS = 7;
   localparam int unsigned CODE_W  = 3;

   typedef enum logic [CODE_W-1:0] {
      CLS_TLZERO = 3'd0,
      CLS_HTIMER = 3'd1,
      CLS_IVEC   = 3'd2,
      CLS_CPUMSG = 3'd3,
      CLS_DEVMSG = 3'd4,
      CLS_RESERR = 3'd5,
      CLS_SOFT   = 3'd6,
      CLS_NONE   = 3'd7
   } cls_e;

endpackage

// File: rtl/intr_soft_lvl.sv
// Highest-set-bit encoder for the soft-interrupt register, plus a flag
// telling whether any other bit survives once the winning bit is masked.
module intr_soft_lvl #(
   parameter int unsigned SOFT_W = 16,
   parameter int unsigned LVL_W  = $clog2(SOFT_W)
) (
   input  logic [SOFT_W-1:0] soft_reg,
   output logic [LVL_W-1:0]  lvl,
   output logic              rest_any
);

   logic [SOFT_W-1:0] top_mask;

   always_comb begin
      lvl = '0;
      for (int i = 0; i < SOFT_W; i++) begin
         if (soft_reg[i]) lvl = LVL_W'(i);
      end
   end

   assign top_mask = {{(SOFT_W-1){1'b0}}, 1'b1} << lvl;
   assign rest_any = |(soft_reg & ~top_mask);

endmodule

// File: rtl/intr_pend_bank.sv
// Pending flags, the untaken counter and the illegal-post pulse.
module intr_pend_bank
   import intr_pkg::*;
#(
   parameter int unsigned CNT_W   = 3,
   parameter bit          ERR_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_vld,
   input  logic [CODE_W-1:0] post_code,
   input  logic              clr_vld,
   input  logic [CODE_W-1:0] clr_idx,
   output logic [NUM_CLS-1:0] flags,
   output logic [CNT_W-1:0]  cnt,
   output logic              post_err
);

   localparam int unsigned SPAN = 1 << CODE_W;

   logic [SPAN-1:0] flg_ext;
   logic            post_legal;
   logic            inc;
   logic            dec;
   logic            bad_post;

   assign flg_ext    = SPAN'(flags);
   assign post_legal = post_vld && (post_code < CODE_W'(NUM_CLS));
   assign bad_post   = post_vld && !post_legal;
   assign inc        = post_legal && !flg_ext[post_code];
   assign dec        = clr_vld && flg_ext[clr_idx] &&
                       !(post_legal && (post_code == clr_idx));

   for (genvar g = 0; g < NUM_CLS; g++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags[g] <= 1'b0;
         end else if (post_legal && (post_code == CODE_W'(g))) begin
            flags[g] <= 1'b1;
         end else if (clr_vld && (clr_idx == CODE_W'(g))) begin
            flags[g] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + CNT_W'(inc) - CNT_W'(dec);
   end

   if (ERR_REG) begin : g_err_reg
      always_ff @(posedge clk) begin
         if (!rst_n) post_err <= 1'b0;
         else        post_err <= bad_post;
      end
   end else begin : g_err_comb
      assign post_err = bad_post;
   end

   AST_CNT_TRACKS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt) == $countones(flags)); // R4
   AST_BAD_POST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      bad_post && !clr_vld |=> $stable(flags)); // R3
   AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      post_legal |=> flg_ext[$past(post_code)]); // R2
   AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vld && !(post_vld && post_code == clr_idx) |=> !flg_ext[$past(clr_idx)]); // R13

endmodule

// File: rtl/intr_prio_sel.sv
// Mode-dependent priority selection over the pending flags.
module intr_prio_sel
   import intr_pkg::*;
#(
   parameter int unsigned LVL_W        = 4,
   parameter int unsigned PIL_W        = 4,
   parameter int unsigned TL_W         = 3,
   parameter int unsigned VEC_RANK_LVL = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_CLS-1:0] flags,
   input  logic               hpriv,
   input  logic               int_en,
   input  logic               tlz_en,
   input  logic [TL_W-1:0]    trap_lvl,
   input  logic [PIL_W-1:0]   pil,
   input  logic [LVL_W-1:0]   soft_lvl,
   output cls_e               sel
);

   logic soft_hi_pil;
   logic soft_low;

   assign soft_hi_pil = (32'(soft_lvl) > 32'(pil));
   assign soft_low    = (32'(soft_lvl) < VEC_RANK_LVL);

   always_comb begin
      sel = CLS_NONE;
      if (hpriv) begin
         if (int_en) begin
            if (flags[CLS_HTIMER])    sel = CLS_HTIMER;
            else if (flags[CLS_IVEC]) sel = CLS_IVEC;
         end
      end else begin
         if (flags[CLS_TLZERO] && tlz_en && (trap_lvl == '0)) begin
            sel = CLS_TLZERO;
         end else if (flags[CLS_HTIMER]) begin
            sel = CLS_HTIMER;
         end else if (int_en) begin
            if (flags[CLS_CPUMSG])                              sel = CLS_CPUMSG;
            else if (flags[CLS_DEVMSG])                         sel = CLS_DEVMSG;
            else if (flags[CLS_SOFT] && soft_low && flags[CLS_IVEC]) sel = CLS_IVEC;
            else if (flags[CLS_SOFT] && soft_hi_pil)            sel = CLS_SOFT;
            else if (flags[CLS_RESERR])                         sel = CLS_RESERR;
         end
      end
   end

   AST_PRIV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      hpriv && !int_en |-> sel == CLS_NONE); // R5
   AST_PRIV_CLASSES: assert property (@(posedge clk) disable iff (!rst_n)
      hpriv && sel != CLS_NONE |-> (sel == CLS_HTIMER || sel == CLS_IVEC)); // R5
   AST_TLZ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      sel == CLS_TLZERO |-> (!hpriv && tlz_en && trap_lvl == '0)); // R6
   AST_SOFT_ABOVE_PIL: assert property (@(posedge clk) disable iff (!rst_n)
      sel == CLS_SOFT |-> 32'(soft_lvl) > 32'(pil)); // R11
   AST_SEL_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      sel != CLS_NONE |-> flags[sel]); // R13

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
   import intr_pkg::*;
#(
   parameter int unsigned SOFT_W       = 16,
   parameter int unsigned TL_W         = 3,
   parameter int unsigned PIL_W        = 4,
   parameter int unsigned VEC_RANK_LVL = 6,
   parameter bit          ERR_REG      = 1'b1,
   localparam int unsigned LVL_W       = $clog2(SOFT_W),
   localparam int unsigned CNT_W       = $clog2(NUM_CLS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              post_vld,
   input  logic [CODE_W-1:0] post_code,
   output logic              post_err,
   input  logic              take_req,
   input  logic              hpriv,
   input  logic              int_en,
   input  logic              tlz_en,
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [PIL_W-1:0]  pil,
   input  logic [SOFT_W-1:0] soft_reg,
   output logic [CODE_W-1:0] take_code,
   output logic              take_vld,
   output logic [LVL_W-1:0]  take_lvl,
   output logic              pend_any,
   output logic [CNT_W-1:0]  pend_cnt
);

   if (PIL_W != LVL_W) begin : g_bad_pil
      $error("PIL_W must equal the soft level width");
   end
   if (SOFT_W < 8) begin : g_bad_soft
      $error("SOFT_W must be at least 8");
   end
   if (VEC_RANK_LVL >= SOFT_W) begin : g_bad_rank
      $error("VEC_RANK_LVL must be below SOFT_W");
   end

   logic [NUM_CLS-1:0] flags;
   logic [LVL_W-1:0]   soft_lvl;
   logic               soft_rest;
   cls_e               sel;
   logic               clr_vld;

   intr_soft_lvl #(.SOFT_W(SOFT_W), .LVL_W(LVL_W)) u_lvl (
      .soft_reg (soft_reg),
      .lvl      (soft_lvl),
      .rest_any (soft_rest)
   );

   intr_prio_sel #(
      .LVL_W(LVL_W), .PIL_W(PIL_W), .TL_W(TL_W), .VEC_RANK_LVL(VEC_RANK_LVL)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flags),
      .hpriv    (hpriv),
      .int_en   (int_en),
      .tlz_en   (tlz_en),
      .trap_lvl (trap_lvl),
      .pil      (pil),
      .soft_lvl (soft_lvl),
      .sel      (sel)
   );

   assign clr_vld = take_req && (sel != CLS_NONE) && !((sel == CLS_SOFT) && soft_rest);

   intr_pend_bank #(.CNT_W(CNT_W), .ERR_REG(ERR_REG)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .post_vld  (post_vld),
      .post_code (post_code),
      .clr_vld   (clr_vld),
      .clr_idx   (sel),
      .flags     (flags),
      .cnt       (pend_cnt),
      .post_err  (post_err)
   );

   assign take_code = sel;
   assign take_vld  = (sel != CLS_NONE);
   assign take_lvl  = (sel == CLS_SOFT) ? soft_lvl : '0;
   assign pend_any  = (pend_cnt != '0);

   AST_SOFT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      take_req && sel == CLS_SOFT && soft_rest && !post_vld |=> $stable(pend_cnt)); // R12
   AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      take_req && take_vld && sel != CLS_SOFT && !post_vld |=> pend_cnt == $past(pend_cnt) - 1'b1); // R13

endmodule

// File: tb/intr_arbiter_tb.sv
`timescale 1ns/1ps
module intr_arbiter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        post_vld = 1'b0;
   logic [2:0]  post_code = '0;
   logic        post_err;
   logic        take_req = 1'b0;
   logic        hpriv = 1'b0;
   logic        int_en = 1'b0;
   logic        tlz_en = 1'b0;
   logic [2:0]  trap_lvl = '0;
   logic [3:0]  pil = '0;
   logic [15:0] soft_reg = '0;
   logic [2:0]  take_code;
   logic        take_vld;
   logic [3:0]  take_lvl;
   logic        pend_any;
   logic [2:0]  pend_cnt;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   intr_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .post_vld(post_vld), .post_code(post_code),
      .post_err(post_err), .take_req(take_req), .hpriv(hpriv), .int_en(int_en),
      .tlz_en(tlz_en), .trap_lvl(trap_lvl), .pil(pil), .soft_reg(soft_reg),
      .take_code(take_code), .take_vld(take_vld), .take_lvl(take_lvl),
      .pend_any(pend_any), .pend_cnt(pend_cnt)
   );

   // {mask[6:0], hpriv, int_en, tlz_en, trap_lvl[2:0], pil[3:0], soft[15:0],
   //  expected code[2:0], expected lvl[3:0], requirement[3:0]}
   localparam int NV = 18;
   localparam logic [43:0] VEC [NV] = '{
      {7'b0000010, 1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 16'h0000, 3'd1, 4'd0, 4'd5},  // R5
      {7'b0000110, 1'b1, 1'b0, 1'b0, 3'd0, 4'd0, 16'h0000, 3'd7, 4'd0, 4'd5},  // R5
      {7'b1111001, 1'b1, 1'b1, 1'b1, 3'd0, 4'd0, 16'h8000, 3'd7, 4'd0, 4'd5},  // R5
      {7'b0000100, 1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 16'h0000, 3'd2, 4'd0, 4'd5},  // R5
      {7'b0000011, 1'b0, 1'b0, 1'b1, 3'd0, 4'd0, 16'h0000, 3'd0, 4'd0, 4'd6},  // R6
      {7'b0000011, 1'b0, 1'b0, 1'b1, 3'd2, 4'd0, 16'h0000, 3'd1, 4'd0, 4'd6},  // R6
      {7'b0000011, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 16'h0000, 3'd1, 4'd0, 4'd6},  // R6
      {7'b1111010, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 16'h8000, 3'd1, 4'd0, 4'd7},  // R7
      {7'b1111000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 16'h8000, 3'd3, 4'd0, 4'd8},  // R8
      {7'b1110000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 16'h8000, 3'd4, 4'd0, 4'd8},  // R8
      {7'b1100000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd3, 16'h0400, 3'd6, 4'd10, 4'd9}, // R8 R9
      {7'b0100000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 16'h0000, 3'd5, 4'd0, 4'd8},  // R8
      {7'b1001000, 1'b0, 1'b0, 1'b0, 3'd0, 4'd0, 16'h8000, 3'd7, 4'd0, 4'd8},  // R8
      {7'b1000100, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 16'h0010, 3'd2, 4'd0, 4'd10}, // R10
      {7'b1000100, 1'b0, 1'b1, 1'b0, 3'd0, 4'd0, 16'h0040, 3'd6, 4'd6, 4'd10}, // R10
      {7'b1100000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd5, 16'h0020, 3'd5, 4'd0, 4'd11}, // R11
      {7'b1000000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd8, 16'h0100, 3'd7, 4'd0, 4'd11}, // R11
      {7'b1000000, 1'b0, 1'b1, 1'b0, 3'd0, 4'd8, 16'h0300, 3'd6, 4'd9, 4'd11}  // R11 R12
   };

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; post_vld = 1'b0; take_req = 1'b0; hpriv = 1'b0;
      int_en = 1'b0; tlz_en = 1'b0; trap_lvl = '0; pil = '0; soft_reg = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic post(input int code);
      @(negedge clk);
      post_vld = 1'b1; post_code = 3'(code);
      @(negedge clk);
      post_vld = 1'b0;
   endtask

   task automatic take();
      @(negedge clk);
      take_req = 1'b1;
      @(negedge clk);
      take_req = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      @(negedge clk);
      check("R1 cnt", pend_cnt, 0);
      check("R1 any", pend_any, 0);
      check("R1 err", post_err, 0);
      check("R1 code", take_code, 7);
      check("R1 vld", take_vld, 0);

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [43:0] v;
         int pc, ec, el, exp_cnt;
         string tag;
         v = VEC[i];
         do_reset();
         for (int c = 0; c < 7; c++) if (v[37 + c]) post(c);
         hpriv = v[36]; int_en = v[35]; tlz_en = v[34];
         trap_lvl = v[33:31]; pil = v[30:27]; soft_reg = v[26:11];
         #1;
         ec = int'(v[10:8]); el = int'(v[7:4]);
         pc = $countones(v[43:37]);
         tag = $sformatf("vector %0d R%0d", i, v[3:0]);
         check({tag, " code"}, take_code, ec);
         check({tag, " lvl"}, take_lvl, el);
         check({tag, " cnt"}, pend_cnt, pc);
         take();
         if (ec == 7) exp_cnt = pc;
         else if (ec == 6 && ((v[26:11] & ~(16'h1 << el)) != 16'h0)) exp_cnt = pc; // R12
         else exp_cnt = pc - 1; // R13
         check({tag, " R13 cnt after take"}, pend_cnt, exp_cnt);
      end

      // R3 illegal post
      do_reset();
      post(7);
      check("R3 err pulse", post_err, 1);
      check("R3 cnt", pend_cnt, 0);
      @(negedge clk);
      check("R3 err single", post_err, 0);

      // R4 repost, R2 counting
      do_reset();
      post(3);
      post(3);
      check("R4 cnt", pend_cnt, 1);
      post(5);
      check("R2 cnt", pend_cnt, 2);
      check("R2 any", pend_any, 1);

      // R12 soft flag kept while bits remain
      do_reset();
      int_en = 1'b1; soft_reg = 16'h0300; pil = 4'd0;
      post(6);
      check("R12 code", take_code, 6);
      check("R9 lvl", take_lvl, 9);
      take();
      check("R12 kept cnt", pend_cnt, 1);
      soft_reg = 16'h0100;
      #1;
      check("R9 lvl lower", take_lvl, 8);
      take();
      check("R12 cleared cnt", pend_cnt, 0);
      check("R12 any", pend_any, 0);

      // R13 net update
      do_reset();
      int_en = 1'b1;
      post(1);
      @(negedge clk);
      take_req = 1'b1; post_vld = 1'b1; post_code = 3'd3;
      @(negedge clk);
      take_req = 1'b0; post_vld = 1'b0;
      check("R13 net cnt", pend_cnt, 1);
      check("R13 next code", take_code, 3);
      @(negedge clk);
      take_req = 1'b1; post_vld = 1'b1; post_code = 3'd3;
      @(negedge clk);
      take_req = 1'b0; post_vld = 1'b0;
      check("R13 same class cnt", pend_cnt, 1);
      check("R13 same class code", take_code, 3);
      int_en = 1'b0;
      #1;
      check("R13 none code", take_code, 7);
      take();
      check("R13 none take cnt", pend_cnt, 1);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule